// File: doc/BRIEF.md
# Weighted Priority Command Scheduler

This block accepts command entries tagged with one of three priorities and hands at most one command per scheduler tick to the command executor. Low-priority and high-priority entries wait in their own FIFOs. An immediate command does not go into a FIFO. It sits in a single holding slot and is served on the next tick ahead of anything queued. When no immediate command is waiting, a small rotating counter decides which FIFO to serve, so that high-priority commands get two turns for every one turn of low-priority commands.

Each entry carries a length, up to `MAX_LEN` payload bytes and a Fletcher-16 check value. The length and the check value are verified at the moment the entry is selected, not when it is written. An entry whose check value is wrong is thrown away. A length outside the legal range is taken as a sign that the queue storage is corrupt, so both FIFOs are emptied at once. The block reports drops, purges and rejected enqueues on one-cycle status pulses. Date-time triggering and the execution of commands are handled elsewhere.

Top module: `cmd_sched`

## Requirements
- R1: `in_prio` is encoded as 0 = low, 1 = high, and 2 or 3 = immediate. `out_prio` is encoded as 0 = low, 1 = high, 2 = immediate. A held immediate command is served on the next tick, ahead of any queued command.
- R2: The block dispatches only on a tick and at most one command per tick. `out_valid` is a one-cycle pulse registered on the tick's clock edge, and it never comes in the same cycle as `err_drop`.
- R3: A 2-bit weight counter cycles through 0, 1, 2. Values 0 and 1 favour the high FIFO and value 2 favours the low FIFO. The counter advances on every tick that selects a queued entry, whether that entry is dispatched or dropped. The result is the service order high, high, low.
- R4: When the favoured FIFO is empty, the tick serves the other FIFO. When both FIFOs are empty and no immediate command is held, the tick dispatches nothing.
- R5: Each FIFO releases its entries in the order they were written.
- R6: The check value is Fletcher-16 with both sums starting at 0 and each sum reduced modulo 255. The bytes summed are the length, zero-extended to 8 bits, followed by payload bytes 0 to len-1, where byte i is `in_data[8i+7:8i]`. The result is {sum2, sum1}. A selected entry whose check value does not match is discarded without dispatch, and `err_drop` pulses for one cycle.
- R7: A length is legal when it is between 1 and `MAX_LEN`. When a queued entry with an illegal length is selected, both FIFOs are emptied, `purge` and `err_drop` pulse for one cycle, and the weight counter returns to 0.
- R8: Each FIFO holds `DEPTH` entries. An enqueue into a full FIFO is discarded and `overflow` pulses for one cycle.
- R9: Only one immediate command can be held at a time. A second immediate enqueue that arrives before the held one is dispatched is rejected with an `overflow` pulse.
- R10: After reset both FIFOs are empty, no immediate command is held, the weight counter is 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Enqueue strobe |
| in_prio | input | 2 | Priority of the entry being enqueued |
| in_len | input | LEN_W | Length of the entry in bytes |
| in_data | input | MAX_LEN*8 | Payload bytes, byte 0 in the low bits |
| in_sum | input | 16 | Fletcher-16 check value |
| tick | input | 1 | Scheduler update |
| out_valid | output | 1 | Dispatch pulse |
| out_prio | output | 2 | Priority of the dispatched command |
| out_len | output | LEN_W | Length of the dispatched command |
| out_data | output | MAX_LEN*8 | Payload of the dispatched command |
| err_drop | output | 1 | An entry was discarded for a bad check value or an illegal length |
| purge | output | 1 | Both FIFOs were emptied |
| overflow | output | 1 | An enqueue was rejected |

## Verification
The assertions check, on every cycle, the properties that hold cycle by cycle. A dispatch always follows a tick and never comes together with a drop. The weight counter never reaches 3. Occupancy never exceeds `DEPTH`. A purge leaves both FIFOs empty. A dispatch that follows a held immediate command carries the immediate priority. Only the bench scenarios can show the properties that depend on a sequence of events: the high-high-low order, the fall-through to the other FIFO, FIFO ordering, the counter reset after a purge, and the loss of every queued entry, including the low FIFO's, when a bad length is found. The same holds for which bad check values are caught, and for the rejection of the fifth high entry and of the second immediate command.

// File: rtl/cmd_sched.sv
module cmd_sched #(
  parameter int DEPTH   = 4,
  parameter int MAX_LEN = 4,
  parameter int LEN_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_prio,
  input  logic [LEN_W-1:0]     in_len,
  input  logic [MAX_LEN*8-1:0] in_data,
  input  logic [15:0]          in_sum,
  input  logic                 tick,
  output logic                 out_valid,
  output logic [1:0]           out_prio,
  output logic [LEN_W-1:0]     out_len,
  output logic [MAX_LEN*8-1:0] out_data,
  output logic                 err_drop,
  output logic                 purge,
  output logic                 overflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int DW = MAX_LEN * 8;
  localparam int EW = LEN_W + DW + 16;

  function automatic logic [7:0] add255(input logic [7:0] x, input logic [7:0] y);
    logic [8:0] t;
    t = {1'b0, x} + {1'b0, y};
    if (t >= 9'd255) t = t - 9'd255;
    return t[7:0];
  endfunction

  function automatic logic [15:0] fl16(input logic [LEN_W-1:0] len, input logic [DW-1:0] d);
    logic [7:0] s1, s2;
    s1 = add255(8'd0, 8'(len));
    s2 = s1;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (i < int'(len)) begin
        s1 = add255(s1, d[i*8 +: 8]);
        s2 = add255(s2, s1);
      end
    end
    return {s2, s1};
  endfunction

  logic [EW-1:0] head [2];
  logic [CW-1:0] qcnt [2];
  logic [EW-1:0] imm_e;
  logic          imm_vld;
  logic [1:0]    wcnt;

  logic hi_ne, lo_ne, take_imm, use_q, sel;
  logic [EW-1:0]    cand;
  logic [LEN_W-1:0] c_len;
  logic [DW-1:0]    c_data;
  logic [15:0]      c_sum;
  logic len_ok, sum_ok, do_purge, fire, bad;
  logic in_imm, iq, enq_q, ovf;

  assign hi_ne    = qcnt[1] != '0;
  assign lo_ne    = qcnt[0] != '0;
  assign take_imm = tick && imm_vld;
  assign use_q    = tick && !imm_vld && (hi_ne || lo_ne);
  assign sel      = (wcnt == 2'd2) ? !lo_ne : hi_ne;
  assign cand     = take_imm ? imm_e : head[sel];
  assign {c_len, c_data, c_sum} = cand;
  assign len_ok   = (c_len != '0) && (int'(c_len) <= MAX_LEN);
  assign sum_ok   = fl16(c_len, c_data) == c_sum;
  assign do_purge = use_q && !len_ok;
  assign fire     = (take_imm || use_q) && len_ok && sum_ok;
  assign bad      = (take_imm || use_q) && !(len_ok && sum_ok);

  assign in_imm = in_prio[1];
  assign iq     = in_prio[0];
  assign enq_q  = in_valid && !in_imm && (int'(qcnt[iq]) != DEPTH) && !do_purge;
  assign ovf    = in_valid && (in_imm ? imm_vld : (int'(qcnt[iq]) == DEPTH));

  for (genvar q = 0; q < 2; q++) begin : g_fifo
    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic push, pop;

    assign push    = enq_q && (iq == 1'(q));
    assign pop     = use_q && len_ok && (sel == 1'(q));
    assign head[q] = mem[rp];
    assign qcnt[q] = cnt;

    always_ff @(posedge clk) begin
      if (!rst_n || do_purge) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) begin
          mem[wp] <= {in_len, in_data, in_sum};
          wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
        end
        if (pop) rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end

    // R8
    depth_chk: assert property (@(posedge clk) disable iff (!rst_n) int'(cnt) <= DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imm_vld <= 1'b0;
      imm_e   <= '0;
    end else if (in_valid && in_imm && !imm_vld) begin
      imm_vld <= 1'b1;
      imm_e   <= {in_len, in_data, in_sum};
    end else if (take_imm) begin
      imm_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        wcnt <= 2'd0;
    else if (do_purge) wcnt <= 2'd0;
    else if (use_q)    wcnt <= (wcnt == 2'd2) ? 2'd0 : wcnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prio  <= 2'd0;
      out_len   <= '0;
      out_data  <= '0;
      err_drop  <= 1'b0;
      purge     <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= fire;
      err_drop  <= bad;
      purge     <= do_purge;
      overflow  <= ovf;
      if (fire) begin
        out_prio <= take_imm ? 2'd2 : {1'b0, sel};
        out_len  <= c_len;
        out_data <= c_data;
      end
    end
  end

  // R2
  one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(tick));
  // R2
  no_mix_chk: assert property (@(posedge clk) disable iff (!rst_n) !(out_valid && err_drop));
  // R3
  weight_range_chk: assert property (@(posedge clk) disable iff (!rst_n) wcnt != 2'd3);
  // R7
  purge_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge |-> (qcnt[0] == '0 && qcnt[1] == '0));
  // R1
  imm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(imm_vld)) |-> out_prio == 2'd2);
endmodule

// File: tb/cmd_sched_test.sv
module cmd_sched_test;
  localparam int DEPTH = 4, MAX_LEN = 4, LEN_W = 4, DW = MAX_LEN * 8;

  logic clk = 0, rst_n = 0, in_valid = 0, tick = 0;
  logic [1:0] in_prio = 0;
  logic [LEN_W-1:0] in_len = 0;
  logic [DW-1:0] in_data = 0;
  logic [15:0] in_sum = 0;
  logic out_valid, err_drop, purge, overflow;
  logic [1:0] out_prio;
  logic [LEN_W-1:0] out_len;
  logic [DW-1:0] out_data;

  int errors = 0, checks = 0;
  logic g_v, g_err, g_pg, g_ovf;
  logic [1:0] g_p;
  logic [7:0] g_d;

  always #5 clk = ~clk;

  cmd_sched #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prio(in_prio), .in_len(in_len),
    .in_data(in_data), .in_sum(in_sum), .tick(tick), .out_valid(out_valid),
    .out_prio(out_prio), .out_len(out_len), .out_data(out_data), .err_drop(err_drop),
    .purge(purge), .overflow(overflow));

  // row: [31:28] kind (0 enqueue, 1 tick), [27:24] prio, [23:20] len,
  //      [19:16] expected valid, [15:12] expected prio, [7:0] seed
  localparam logic [31:0] VEC [15] = '{
    32'h0120_0010, 32'h0130_0020, 32'h0110_0030, 32'h0040_0040, 32'h0020_0050,
    32'h1001_1010, 32'h1001_1020, 32'h1001_0040, 32'h1001_1030, 32'h1001_0050,
    32'h1000_0000, 32'h0210_0060, 32'h0120_0070, 32'h1001_2060, 32'h1001_1070
  };

  function automatic logic [15:0] ref_sum(input int len, input int seed);
    int a = 0, b = 0;
    a = len % 255; b = a;
    for (int i = 0; i < len && i < MAX_LEN; i++) begin
      a = (a + ((seed + i) & 255)) % 255;
      b = (b + a) % 255;
    end
    return {b[7:0], a[7:0]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enq(input int prio, input int len, input int seed, input bit corrupt);
    in_valid = 1; in_prio = 2'(prio); in_len = LEN_W'(len);
    in_data = '0;
    for (int i = 0; i < MAX_LEN; i++) if (i < len) in_data[i*8 +: 8] = 8'(seed + i);
    in_sum = ref_sum(len, seed) ^ (corrupt ? 16'h0001 : 16'h0000);
    @(negedge clk);
    g_ovf = overflow;
    in_valid = 0;
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk);
    g_v = out_valid; g_p = out_prio; g_d = out_data[7:0];
    g_err = err_drop; g_pg = purge;
    tick = 0;
  endtask

  task automatic expect_cmd(input string req, input int prio, input int seed);
    do_tick();
    check({req, " valid"}, g_v, 1);
    check({req, " prio"}, g_p, prio);
    check({req, " data"}, g_d, seed);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 out_valid", out_valid, 0);
    check("R10 err_drop", err_drop, 0);
    check("R10 purge", purge, 0);
    check("R10 overflow", overflow, 0);
    do_tick();
    check("R10 empty tick", g_v, 0);

    // Table: R3 weighting, R4 fall-through, R5 order, R1 immediate first
    foreach (VEC[k]) begin
      if (VEC[k][31:28] == 4'd0) begin
        enq(int'(VEC[k][27:24]), int'(VEC[k][23:20]), int'(VEC[k][7:0]), 0);
        check("R8 no overflow", g_ovf, 0);
      end else begin
        do_tick();
        check("R3/R4 valid", g_v, int'(VEC[k][19:16]));
        if (VEC[k][19:16] != 0) begin
          check("R1/R3 prio", g_p, int'(VEC[k][15:12]));
          check("R5 data", g_d, int'(VEC[k][7:0]));
        end
      end
    end

    // R6 bad checksum dropped, next entry still served
    enq(1, 2, 8'h80, 1);
    enq(1, 3, 8'h88, 0);
    do_tick();
    check("R6 drop no valid", g_v, 0);
    check("R6 err pulse", g_err, 1);
    expect_cmd("R6 next", 1, 8'h88);

    // R7 illegal length purges both queues and resets weighting (counter now 2)
    enq(1, 2, 8'hC0, 0);
    enq(1, MAX_LEN + 1, 8'hC8, 0);
    enq(0, 1, 8'h90, 0);
    enq(0, 2, 8'hA0, 0);
    expect_cmd("R7 pre low", 0, 8'h90);
    expect_cmd("R7 pre high", 1, 8'hC0);
    do_tick();
    check("R7 purge pulse", g_pg, 1);
    check("R7 err pulse", g_err, 1);
    check("R7 no valid", g_v, 0);
    do_tick();
    check("R7 low queue cleared", g_v, 0);
    enq(1, 1, 8'hD1, 0);
    enq(1, 1, 8'hD2, 0);
    enq(0, 1, 8'hD0, 0);
    expect_cmd("R7 reset order 1", 1, 8'hD1);
    expect_cmd("R7 reset order 2", 1, 8'hD2);
    expect_cmd("R7 reset order 3", 0, 8'hD0);

    // R8 full queue rejects
    for (int i = 0; i < DEPTH; i++) begin
      enq(1, 1, 8'hE0 + i, 0);
      check("R8 fill ok", g_ovf, 0);
    end
    enq(1, 1, 8'hEF, 0);
    check("R8 overflow pulse", g_ovf, 1);
    for (int i = 0; i < DEPTH; i++) expect_cmd("R8 drain", 1, 8'hE0 + i);
    do_tick();
    check("R8 dropped entry absent", g_v, 0);

    // R9 second immediate rejected
    enq(2, 1, 8'hF0, 0);
    check("R9 first accepted", g_ovf, 0);
    enq(3, 1, 8'hF1, 0);
    check("R9 second rejected", g_ovf, 1);
    expect_cmd("R9 held served", 2, 8'hF0);
    do_tick();
    check("R9 nothing more", g_v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule